// File: doc/BRIEF.md
# Stereo PCM Serial Transmitter (Left-Justified / I2S)

This block takes pairs of 24-bit two's-complement audio samples and sends them, most significant bit first, on one serial data line along with a bit clock and a left/right frame clock. A single control bit picks the framing. With `fmt_i2s` low the frame is left-justified: the frame clock is high during the left channel and the MSB goes out in the first bit slot after a frame-clock edge. With `fmt_i2s` high the frame is I2S: the frame clock is low during the left channel and the MSB goes out one bit slot late, so the first slot carries a zero. In every frame the left word goes first and the right word of the same pair follows. All slots after the LSB carry zero until the next frame-clock edge.

With `master_en` high the block makes both clocks itself. Each level of the bit clock lasts `div_sel+1` cycles of `clk`. Each channel half is `SLOT_BITS` (32) bit clocks long, so a frame is 64 bit clocks and the frame clock has a 50% duty cycle. With `master_en` low the block follows the external `bclk_in` and `lrclk_in`, which pass through a two-stage synchronizer. A channel half may then be any length from the word length up to 64 bit clocks, which is 128 bit clocks per frame. That is the single-speed limit; double- and quad-speed sources stay at or below 64 per frame. Data changes only after a falling bit-clock edge, so a receiver samples on the rising edge. `master_en`, `fmt_i2s` and `div_sel` are configuration inputs and are changed only while reset is held.

Samples come in through a valid/ready handshake. A one-pair holding register is loaded whenever it is empty, and it is emptied when the left channel of a frame starts. If the register is empty at that point, the whole frame is sent as zeros. The `mute` level seen at the start of a left channel zeroes that whole frame, and the held pair is still consumed. The engine is a four-state machine advanced only on falling bit-clock edges:
- WAIT: after reset, idles until the first left-channel start.
- GAP: the I2S zero slot.
- SHIFT: the word bits.
- PAD: zero fill.

Its transitions are:
- start: any state to GAP (I2S) or SHIFT (left-justified), on a frame-clock change. From WAIT, only a change into the left channel counts.
- gap_done: GAP to SHIFT.
- word_done: SHIFT to PAD, after the LSB.
- hold: every other falling edge leaves the state unchanged.

Top module: `pcm_serial_tx`

## Requirements
- R1: While `rst_n` is low: `sdout`=0, `smp_ready`=1 and `bclk_out`=0. `lrclk_out` shows the left level in master mode (1 when `fmt_i2s`=0, 0 when `fmt_i2s`=1) and 0 in slave mode.
- R2: In master mode, each high and each low level of `bclk_out` lasts exactly `div_sel+1` cycles of `clk`.
- R3: In master mode, `lrclk_out` changes only in the cycle in which `bclk_out` falls. Each channel half spans 32 bit clocks, so 31 further falling edges come between two frame-clock changes. Left level: high when `fmt_i2s`=0, low when `fmt_i2s`=1.
- R4: The left word is sent MSB first, bit 23 down to bit 0. With `fmt_i2s`=0, bit 23 occupies the first slot after the frame-clock edge. With `fmt_i2s`=1 it occupies the second slot, and the first slot is 0.
- R5: The right word of the same pair follows in the right channel half, with the same slot alignment as the left word.
- R6: Every slot after bit 0 carries 0 until the next frame-clock edge.
- R7: `sdout` changes only in response to a falling bit-clock edge. In master mode this is the same `clk` cycle in which `bclk_out` falls. In slave mode it is the third `clk` edge after `bclk_in` falls.
- R8: In slave mode, timing follows `bclk_in` and `lrclk_in`, with channel halves of 24 to 64 slots, and `bclk_out` and `lrclk_out` are held at 0.
- R9: A pair is accepted when `smp_valid` and `smp_ready` are both high at a clock edge. `smp_ready` is low in the following cycle and rises again when a left channel starts.
- R10: If no pair is held when a left channel starts, that left word and the following right word are all zeros.
- R11: If `mute` is high at the start of a left channel, that whole frame is zeros, and the held pair is consumed and discarded.
- R12: After reset nothing but zeros is sent until the first change of the frame clock into the left channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the master clock for the divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1: generate clocks, 0: follow external clocks |
| fmt_i2s | input | 1 | 0: left-justified, 1: I2S framing |
| div_sel | input | 3 | Master bit-clock level length minus one, in `clk` cycles |
| mute | input | 1 | Zero the frame that starts next |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Holding register empty |
| left_data | input | 24 | Left sample, two's complement |
| right_data | input | 24 | Right sample, two's complement |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrclk_in | input | 1 | External frame clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| lrclk_out | output | 1 | Generated frame clock (master mode) |
| sdout | output | 1 | Serial data |

## Verification
The hardest case to reach is a frame start that falls in the same cycle a pair is accepted into an empty holding register. The engine then sends zeros, while the new pair is kept for the next frame. The stimulus gets there by withholding the feed for several frames and then resuming it at an arbitrary point, with the bench's model applying takes and acceptances in the order they occur at one edge. Slave operation is started partway through a left half, so the first frame-clock change the engine sees is into the right channel and has to be ignored. Slave runs also cover a channel half exactly as long as the word.

// File: rtl/stx_pkg.sv
package stx_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_GAP   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_PAD   = 2'd3
    } stx_state_t;
endpackage

// File: rtl/stx_clkgen.sv
// Bit/frame clock front end: generates clocks in master mode, synchronizes
// external ones in slave mode; emits one fall event per bit period and the
// channel (1 = right) of the bit period that the event opens.
module stx_clkgen #(
    parameter int SLOT_BITS   = 32,
    parameter int DIV_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic             fmt_i2s,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             bclk_in,
    input  logic             lrclk_in,
    output logic             fall_evt,
    output logic             right_nxt,
    output logic             bclk_out,
    output logic             lrclk_out
);
    localparam int POS_W = $clog2(2 * SLOT_BITS);

    logic [DIV_W-1:0]       div_cnt;
    logic                   bck_q;
    logic [POS_W-1:0]       bitpos;
    logic [POS_W-1:0]       pos_nxt;
    logic                   tick;
    logic [SYNC_STAGES-1:0] bsync;
    logic [SYNC_STAGES-1:0] lsync;
    logic                   b_d;
    logic                   m_right;

    assign tick    = (div_cnt == div_sel);
    assign pos_nxt = bitpos + POS_W'(1);
    assign m_right = bitpos[POS_W-1];

    // master divider: bitpos starts at the end of the left half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bck_q   <= 1'b0;
            bitpos  <= POS_W'(SLOT_BITS - 1);
        end else if (master_en) begin
            if (tick) begin
                div_cnt <= '0;
                bck_q   <= ~bck_q;
                if (bck_q) begin
                    bitpos <= pos_nxt;
                end
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    // slave synchronizers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bsync <= '0;
            lsync <= '0;
            b_d   <= 1'b0;
        end else begin
            bsync <= {bsync[SYNC_STAGES-2:0], bclk_in};
            lsync <= {lsync[SYNC_STAGES-2:0], lrclk_in};
            b_d   <= bsync[SYNC_STAGES-1];
        end
    end

    always_comb begin
        if (master_en) begin
            fall_evt  = tick & bck_q;
            right_nxt = pos_nxt[POS_W-1];
        end else begin
            fall_evt  = b_d & ~bsync[SYNC_STAGES-1];
            right_nxt = fmt_i2s ? lsync[SYNC_STAGES-1] : ~lsync[SYNC_STAGES-1];
        end
    end

    assign bclk_out  = master_en & bck_q;
    assign lrclk_out = master_en & (fmt_i2s ? m_right : ~m_right);
endmodule

// File: rtl/stx_inbuf.sv
// One-pair holding register between the handshake and the engine.
module stx_inbuf #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] left_data,
    input  logic [WORD_W-1:0] right_data,
    input  logic              take,
    output logic              smp_ready,
    output logic              buf_full,
    output logic [WORD_W-1:0] buf_l,
    output logic [WORD_W-1:0] buf_r
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            buf_l    <= '0;
            buf_r    <= '0;
        end else if (smp_valid && !buf_full) begin
            buf_full <= 1'b1;
            buf_l    <= left_data;
            buf_r    <= right_data;
        end else if (take) begin
            buf_full <= 1'b0;
        end
    end

    assign smp_ready = ~buf_full;
endmodule

// File: rtl/stx_engine.sv
// Framing state machine, advanced once per falling bit-clock event.
module stx_engine
    import stx_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_evt,
    input  logic              right_nxt,
    input  logic              fmt_i2s,
    input  logic              mute,
    input  logic              buf_full,
    input  logic [WORD_W-1:0] buf_l,
    input  logic [WORD_W-1:0] buf_r,
    output logic              take,
    output logic              sdout
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    stx_state_t        state, state_nxt;
    logic              right_prev;
    logic              start;
    logic              use_buf;
    logic [WORD_W-1:0] load_word;
    logic [WORD_W-1:0] r_word;
    logic [WORD_W-1:0] sreg;
    logic [CNT_W-1:0]  cnt;

    assign start   = fall_evt && (right_nxt != right_prev)
                     && ((state != ST_WAIT) || !right_nxt);
    assign use_buf = buf_full && !mute;
    assign take    = start && !right_nxt;

    always_comb begin
        if (right_nxt) begin
            load_word = r_word;
        end else begin
            load_word = use_buf ? buf_l : '0;
        end
    end

    always_comb begin
        state_nxt = state;
        if (start) begin
            state_nxt = fmt_i2s ? ST_GAP : ST_SHIFT;
        end else if (fall_evt) begin
            unique case (state)
                ST_WAIT:  state_nxt = ST_WAIT;
                ST_GAP:   state_nxt = ST_SHIFT;
                ST_SHIFT: state_nxt = (cnt == CNT_W'(WORD_W)) ? ST_PAD : ST_SHIFT;
                ST_PAD:   state_nxt = ST_PAD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            right_prev <= 1'b0;
            r_word     <= '0;
            sreg       <= '0;
            cnt        <= '0;
            sdout      <= 1'b0;
        end else if (fall_evt) begin
            right_prev <= right_nxt;
            if (start) begin
                if (!right_nxt) begin
                    r_word <= use_buf ? buf_r : '0;
                end
                if (fmt_i2s) begin
                    sreg  <= load_word;
                    cnt   <= '0;
                    sdout <= 1'b0;
                end else begin
                    sreg  <= {load_word[WORD_W-2:0], 1'b0};
                    cnt   <= CNT_W'(1);
                    sdout <= load_word[WORD_W-1];
                end
            end else begin
                unique case (state)
                    ST_GAP: begin
                        sdout <= sreg[WORD_W-1];
                        sreg  <= {sreg[WORD_W-2:0], 1'b0};
                        cnt   <= CNT_W'(1);
                    end
                    ST_SHIFT: begin
                        if (cnt == CNT_W'(WORD_W)) begin
                            sdout <= 1'b0;
                        end else begin
                            sdout <= sreg[WORD_W-1];
                            sreg  <= {sreg[WORD_W-2:0], 1'b0};
                            cnt   <= cnt + CNT_W'(1);
                        end
                    end
                    ST_WAIT, ST_PAD: sdout <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx #(
    parameter int WORD_W    = 24,
    parameter int SLOT_BITS = 32,
    parameter int DIV_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              fmt_i2s,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              mute,
    input  logic              smp_valid,
    output logic              smp_ready,
    input  logic [WORD_W-1:0] left_data,
    input  logic [WORD_W-1:0] right_data,
    input  logic              bclk_in,
    input  logic              lrclk_in,
    output logic              bclk_out,
    output logic              lrclk_out,
    output logic              sdout
);
    logic              fall_evt;
    logic              right_nxt;
    logic              take;
    logic              buf_full;
    logic [WORD_W-1:0] buf_l;
    logic [WORD_W-1:0] buf_r;

    stx_clkgen #(.SLOT_BITS(SLOT_BITS), .DIV_W(DIV_W), .SYNC_STAGES(2)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .fmt_i2s   (fmt_i2s),
        .div_sel   (div_sel),
        .bclk_in   (bclk_in),
        .lrclk_in  (lrclk_in),
        .fall_evt  (fall_evt),
        .right_nxt (right_nxt),
        .bclk_out  (bclk_out),
        .lrclk_out (lrclk_out)
    );

    stx_inbuf #(.WORD_W(WORD_W)) u_inbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .left_data  (left_data),
        .right_data (right_data),
        .take       (take),
        .smp_ready  (smp_ready),
        .buf_full   (buf_full),
        .buf_l      (buf_l),
        .buf_r      (buf_r)
    );

    stx_engine #(.WORD_W(WORD_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_evt  (fall_evt),
        .right_nxt (right_nxt),
        .fmt_i2s   (fmt_i2s),
        .mute      (mute),
        .buf_full  (buf_full),
        .buf_l     (buf_l),
        .buf_r     (buf_r),
        .take      (take),
        .sdout     (sdout)
    );
endmodule

// File: rtl/stx_chk.sv
module stx_chk (
    input logic clk,
    input logic rst_n,
    input logic master_en,
    input logic fmt_i2s,
    input logic smp_valid,
    input logic smp_ready,
    input logic bclk_out,
    input logic lrclk_out,
    input logic sdout
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_state_chk: assert (!sdout && smp_ready && !bclk_out);
        end
    end

    // R7
    sdout_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && !$stable(sdout)) |-> $fell(bclk_out));

    // R3
    frame_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && !$stable(lrclk_out)) |-> $fell(bclk_out));

    // R4
    i2s_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && fmt_i2s && !$stable(lrclk_out)) |-> !sdout);

    // R9
    accept_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready);

    // R8
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> (!bclk_out && !lrclk_out));
endmodule

bind pcm_serial_tx stx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (master_en),
    .fmt_i2s   (fmt_i2s),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .bclk_out  (bclk_out),
    .lrclk_out (lrclk_out),
    .sdout     (sdout)
);

// File: tb/pcm_serial_tx_bench.sv
module pcm_serial_tx_bench;
    localparam int WORD_W    = 24;
    localparam int SLOT_BITS = 32;
    localparam int DIV_W     = 3;
    localparam int S_HALF    = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n, master_en, fmt_i2s, mute, smp_valid, smp_ready;
    logic              bclk_in, lrclk_in, bclk_out, lrclk_out, sdout;
    logic [DIV_W-1:0]  div_sel;
    logic [WORD_W-1:0] left_data, right_data;

    pcm_serial_tx u_pcm_serial_tx (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .fmt_i2s(fmt_i2s),
        .div_sel(div_sel), .mute(mute), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .left_data(left_data), .right_data(right_data), .bclk_in(bclk_in),
        .lrclk_in(lrclk_in), .bclk_out(bclk_out), .lrclk_out(lrclk_out), .sdout(sdout)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;
    bit feed_en = 0, slv_run = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [WORD_W-1:0] pat(input int i);
        case (i % 8)
            0: pat = 24'h800000;
            1: pat = 24'h7FFFFF;
            2: pat = 24'h000001;
            3: pat = 24'hFFFFFF;
            default: pat = WORD_W'((i * 32'h9E3779) ^ 32'h5A5A5A);
        endcase
    endfunction

    // feeder: offers pair after pair while enabled
    int feed_idx = 0;
    initial begin
        bit hs_f;
        smp_valid = 0; left_data = '0; right_data = '0;
        forever begin
            @(negedge clk);
            hs_f = smp_valid && smp_ready;
            @(posedge clk); #1;
            if (hs_f) feed_idx++;
            smp_valid  = feed_en;
            left_data  = pat(2 * feed_idx);
            right_data = pat(2 * feed_idx + 1);
        end
    end

    // external clock source for slave mode
    int s_div = 0, s_slot = 0, s_per_half = 32;
    bit s_right = 0;
    initial begin
        forever begin
            @(posedge clk); #1;
            if (slv_run) begin
                if (s_div == S_HALF - 1) begin
                    s_div = 0;
                    if (bclk_in) begin
                        bclk_in = 0;
                        s_slot++;
                        if (s_slot == s_per_half) begin
                            s_slot  = 0;
                            s_right = !s_right;
                        end
                        lrclk_in = fmt_i2s ? s_right : !s_right;
                    end else begin
                        bclk_in = 1;
                    end
                end else begin
                    s_div++;
                end
            end
        end
    end

    // behavioural reference model
    bit m_started, m_right_prev, m_rightch, m_pend, m_hs, m_mute_q, m_exp, m_psd;
    int m_slot, m_kind, m_run, m_nfall;
    bit m_run_ok, m_half_ok, m_pb, m_plr, s_pb;
    logic [WORD_W-1:0] m_cur, m_nxt, m_pend_l, m_pend_r, m_hs_l, m_hs_r;
    bit pf[3];
    bit pl[3];
    bit fall_now, lr_now, lr_chg;

    task automatic model_fall(input bit lr);
        bit right;
        int idx;
        right = fmt_i2s ? lr : !lr;
        if (right != m_right_prev && (m_started || !right)) begin
            m_started = 1;
            m_slot = 0;
            if (!right) begin
                if (m_pend && !m_mute_q) begin
                    m_cur = m_pend_l; m_nxt = m_pend_r; m_kind = 0;
                end else begin
                    m_cur = '0; m_nxt = '0; m_kind = m_pend ? 1 : 2;
                end
                m_pend = 0;
            end else begin
                m_cur = m_nxt;
            end
            m_rightch = right;
        end else begin
            m_slot++;
        end
        m_right_prev = right;
        idx = m_slot - (fmt_i2s ? 1 : 0);
        if (m_started && idx >= 0 && idx < WORD_W) m_exp = m_cur[WORD_W-1-idx];
        else m_exp = 0;
    endtask

    function automatic string bit_tag();
        int idx;
        idx = m_slot - (fmt_i2s ? 1 : 0);
        if (!m_started) return "R12";
        if (m_kind == 1) return "R11";
        if (m_kind == 2) return "R10";
        if (idx < 0 || idx >= WORD_W) return "R6";
        return m_rightch ? "R5" : "R4";
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            m_started = 0; m_right_prev = 0; m_rightch = 0; m_pend = 0; m_hs = 0;
            m_mute_q = 0; m_exp = 0; m_psd = 0; m_slot = 0; m_kind = 0;
            m_run = 0; m_nfall = 0; m_run_ok = 0; m_half_ok = 0;
            m_cur = '0; m_nxt = '0;
            m_pb = bclk_out; m_plr = lrclk_out; s_pb = bclk_in;
            for (int i = 0; i < 3; i++) begin pf[i] = 0; pl[i] = 0; end
        end else if (!done) begin
            fall_now = 0; lr_now = 0;
            if (master_en) begin
                if (m_pb && !bclk_out) begin fall_now = 1; lr_now = lrclk_out; end
                if (bclk_out != m_pb) begin
                    if (m_run_ok) check(m_run == int'(div_sel) + 1, "R2", m_run, int'(div_sel) + 1);
                    m_run_ok = 1; m_run = 1;
                end else begin
                    m_run++;
                end
                lr_chg = (lrclk_out != m_plr);
                if (lr_chg) check(fall_now, "R3", 0, 1);
                if (fall_now) begin
                    if (lr_chg) begin
                        if (m_half_ok) check(m_nfall == SLOT_BITS - 1, "R3", m_nfall, SLOT_BITS - 1);
                        m_half_ok = 1; m_nfall = 0;
                    end else begin
                        m_nfall++;
                    end
                end
                m_pb = bclk_out; m_plr = lrclk_out;
            end else begin
                fall_now = pf[2]; lr_now = pl[2];
                pf[2] = pf[1]; pl[2] = pl[1];
                pf[1] = pf[0]; pl[1] = pl[0];
                pf[0] = s_pb && !bclk_in; pl[0] = lrclk_in;
                s_pb = bclk_in;
                check(!bclk_out && !lrclk_out, "R8", {bclk_out, lrclk_out}, 0);
            end
            if (fall_now) model_fall(lr_now);
            if (m_hs) begin
                m_pend = 1; m_pend_l = m_hs_l; m_pend_r = m_hs_r;
                check(!smp_ready, "R9", smp_ready, 0);
            end
            m_hs = smp_valid && smp_ready;
            m_hs_l = left_data; m_hs_r = right_data;
            m_mute_q = mute;
            check(sdout === m_exp, bit_tag(), sdout, m_exp);
            if (sdout !== m_psd) check(fall_now, "R7", 0, 1);
            m_psd = sdout;
        end
    end

    task automatic phase_reset(input bit m, input bit f, input logic [DIV_W-1:0] d,
                               input int per_half, input int start_slot);
        feed_en = 0; slv_run = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 0; master_en = m; fmt_i2s = f; div_sel = d; mute = 0;
        bclk_in = 1; s_right = 0; s_slot = start_slot; s_per_half = per_half; s_div = 0;
        lrclk_in = f ? 1'b0 : 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(sdout == 0, "R1", sdout, 0);
        check(smp_ready == 1, "R1", smp_ready, 1);
        check(bclk_out == 0, "R1", bclk_out, 0);
        check(lrclk_out == (m ? !f : 1'b0), "R1", lrclk_out, m ? !f : 1'b0);
        @(posedge clk); #1;
        rst_n = 1; feed_en = 1; slv_run = !m;
    endtask

    initial begin
        rst_n = 0; master_en = 1; fmt_i2s = 0; div_sel = 3'd1; mute = 0;
        bclk_in = 1; lrclk_in = 1;
        // master, left-justified, with an underrun gap (R10)
        phase_reset(1, 0, 3'd1, 32, 0);
        repeat (1500) @(posedge clk);
        #1 feed_en = 0;
        repeat (600) @(posedge clk);
        #1 feed_en = 1;
        repeat (900) @(posedge clk);
        // master, I2S, with a mute window (R11)
        phase_reset(1, 1, 3'd0, 32, 0);
        repeat (600) @(posedge clk);
        #1 mute = 1;
        repeat (300) @(posedge clk);
        #1 mute = 0;
        repeat (700) @(posedge clk);
        // master, left-justified, slow divider (R2)
        phase_reset(1, 0, 3'd4, 32, 0);
        repeat (1800) @(posedge clk);
        // slave, left-justified, 32 slots per half, started mid-left (R8, R12)
        phase_reset(0, 0, 3'd0, 32, 10);
        repeat (3500) @(posedge clk);
        // slave, I2S, 64 slots per half with an underrun gap
        phase_reset(0, 1, 3'd0, 64, 10);
        repeat (2500) @(posedge clk);
        #1 feed_en = 0;
        repeat (1600) @(posedge clk);
        #1 feed_en = 1;
        repeat (2500) @(posedge clk);
        // slave, left-justified, half exactly one word long, with mute
        phase_reset(0, 0, 3'd0, 24, 5);
        repeat (1500) @(posedge clk);
        #1 mute = 1;
        repeat (400) @(posedge clk);
        #1 mute = 0;
        repeat (1200) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog R9 actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule